// File: doc/BRIEF.md
# Serial Register Access Slave

This block is the slave end of a four-wire serial control port. A host moves a shift clock, a data line and a commit strobe to write 8-bit configuration registers held inside the block. It can also read any of those registers back on a separate output line. All port pins are oversampled on the block's own clock. Edges of the shift clock and of the strobe are found by comparing each pin with its value at the previous clock.

Each frame is 14 bits: a 6-bit address followed by an 8-bit word. Address bit 4 chooses the operation. When it is clear, the frame is a write. When it is set, the frame is a read, the word is a don't-care, and the register at the same address with bit 4 cleared is returned serially. A 2-bit output-mode field lives in one of the registers. When that field is non-zero, a read returns an external error-flag vector in place of the register. The output line is enabled only while a read transfer is running and the active-low output-enable pin is low. This lets the data input and the data output share one wire.

Top module: `serial_reg_slave`

## Requirements
- R1: A frame is taken from `sdi_i`, sampled at each rising edge of `sck_i`, most significant bit first. When more than 14 bits arrive before a commit, only the last 14 count. Frame bits [13:8] are the address and bits [7:0] are the word.
- R2: A rising edge on `sen_i` with at least 14 bits shifted and address bit 4 clear writes the word to register index {a5,a3,a2,a1,a0}. That register appears at `regs_o[8*index +: 8]`. No other event changes `regs_o`.
- R3: A rising edge on `sen_i` after fewer than 14 bits changes no register and starts no read. Every `sen_i` rising edge empties the input shifter and its bit count.
- R4: A committed frame with address bit 4 set changes no register. It starts a read of register index {a5,a3,a2,a1,a0}.
- R5: Read data leaves on `sdo_o` most significant bit first. The first bit is presented in the clock after the commit. The next bit follows each falling edge of `sck_i`. The transfer ends after the 8th falling edge.
- R6: The output-mode field is bits [1:0] of register index 15 (address 0x0F). When it is 00, a read returns the register. Otherwise a read returns `err_flags_i` as sampled at the commit.
- R7: `sdo_oe_o` is high only while a transfer is running and `oeb_i` is low. `sdo_o` is 0 whenever `sdo_oe_o` is low.
- R8: A new frame can be shifted in on `sdi_i` while a read is still leaving on `sdo_o`. Neither one disturbs the other.
- R9: Reset clears every register, and with it the output-mode field, and holds `sdo_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in |
| sen_i | input | 1 | Commit strobe (rising edge acts) |
| oeb_i | input | 1 | Active-low enable for the data output |
| err_flags_i | input | 8 | Error flags returned when output mode is non-zero |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for the data output pad |
| regs_o | output | 8*NUM_REGS | Flattened register bank contents |

## Verification
The hardest case to reach is a read whose output is still leaving while the host already shifts the next frame in on the same clock edges. It only arises when `sdi_i` and `sdo_o` are treated as separate wires. The stimulus reaches it by committing a read and then sending a full write frame straight away. The first eight shift clocks of that write carry the read data out, and the write itself must still land. The reference model holds the input bits and the pending output bits in two independent queues, so any coupling between the two paths shows up on the clock where it happens.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int IDX_W   = 5;
  localparam int RD_BIT  = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic logic [IDX_W-1:0] reg_idx(logic [ADDR_W-1:0] a);
    return {a[5], a[3:0]};
  endfunction

  function automatic logic is_read(logic [ADDR_W-1:0] a);
    return a[RD_BIT];
  endfunction
endpackage

// File: rtl/srs_edge.sv
module srs_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_i;

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
    assign fall_o[g] = ~sig_i[g] & sig_q[g];
  end
endmodule

// File: rtl/srs_rx.sv
module srs_rx
  import srs_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_rise_i,
  input  logic             sen_rise_i,
  input  logic             sdi_i,
  output logic             commit_o,
  output frame_t           frame_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               full;

  assign full = (cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (sen_rise_i) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (sck_rise_i) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_i};
      if (!full) cnt <= cnt + 1'b1;
    end
  end

  assign commit_o  = sen_rise_i & full;
  assign frame_o   = shreg;
  assign bit_cnt_o = cnt;
endmodule

// File: rtl/srs_bank.sv
module srs_bank
  import srs_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int CTRL_IDX = 15
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [IDX_W-1:0]           rd_idx_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [1:0]                 mode_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                 regs[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))   regs[g] <= wr_data_i;
    assign regs_o[g*DATA_W +: DATA_W] = regs[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs[i];
  end

  assign mode_o = regs[CTRL_IDX][1:0];
endmodule

// File: rtl/srs_tx.sv
module srs_tx
  import srs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sck_fall_i,
  output logic              bit_o,
  output logic              active_o
);
  localparam int LEFT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh;
  logic [LEFT_W-1:0] left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh   <= '0;
      left <= '0;
    end else if (load_i) begin
      sh   <= load_data_i;
      left <= LEFT_W'(DATA_W);
    end else if (sck_fall_i && left != '0) begin
      sh   <= {sh[DATA_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign active_o = (left != '0);
  assign bit_o    = sh[DATA_W-1];
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import srs_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int CTRL_IDX = 15
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sck_i,
  input  logic                       sdi_i,
  input  logic                       sen_i,
  input  logic                       oeb_i,
  input  logic [DATA_W-1:0]          err_flags_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [1:0]         rise, fall;
  logic               commit, tx_active, tx_bit;
  frame_t             frame;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-1:0]  rd_data;
  logic [1:0]         mode;
  logic               do_wr, do_rd;

  srs_edge #(.W(2)) u_edge (
    .clk_i, .rst_ni,
    .sig_i  ({sen_i, sck_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  srs_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni,
    .sck_rise_i (rise[0]),
    .sen_rise_i (rise[1]),
    .sdi_i,
    .commit_o   (commit),
    .frame_o    (frame),
    .bit_cnt_o  (bit_cnt)
  );

  assign do_wr = commit & ~is_read(frame.addr);
  assign do_rd = commit &  is_read(frame.addr);

  srs_bank #(.NUM_REGS(NUM_REGS), .CTRL_IDX(CTRL_IDX)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i   (do_wr),
    .wr_idx_i  (reg_idx(frame.addr)),
    .wr_data_i (frame.data),
    .rd_idx_i  (reg_idx(frame.addr)),
    .rd_data_o (rd_data),
    .mode_o    (mode),
    .regs_o
  );

  srs_tx u_tx (
    .clk_i, .rst_ni,
    .load_i      (do_rd),
    .load_data_i ((mode == 2'b00) ? rd_data : err_flags_i),
    .sck_fall_i  (fall[0]),
    .bit_o       (tx_bit),
    .active_o    (tx_active)
  );

  assign sdo_oe_o = tx_active & ~oeb_i;
  assign sdo_o    = sdo_oe_o & tx_bit;
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int NUM_REGS = 32,
  parameter int CNT_W    = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sck_i,
  input logic                  sen_i,
  input logic                  sdo_o,
  input logic                  sdo_oe_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  tx_active,
  input logic [CNT_W-1:0]      bit_cnt
);
  // R2
  regs_only_on_sen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(sen_i));

  // R3
  cnt_moves_on_edges_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt != $past(bit_cnt)) |-> ($past(sck_i) || $past(sen_i)));

  // R4
  read_starts_on_sen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active) |-> $past(sen_i));

  // R5
  sdo_moves_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$stable(sdo_o)) |-> (!$past(sck_i) || $past(sen_i)));

  // R5
  tx_ends_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_active) |-> !$past(sck_i));

  // R9
  always @(posedge clk_i)
    if (!rst_ni) reset_quiet_chk: assert (!sdo_oe_o && regs_o == '0);
endmodule

bind serial_reg_slave srs_chk #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sck_i     (sck_i),
  .sen_i     (sen_i),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o),
  .regs_o    (regs_o),
  .tx_active (tx_active),
  .bit_cnt   (bit_cnt)
);

// File: tb/sim_serial_reg_slave.sv
`timescale 1ns/1ps
module sim_serial_reg_slave;
  localparam int NR = 32;

  logic clk_i = 0, rst_ni = 0;
  logic sck_i = 0, sdi_i = 0, sen_i = 0, oeb_i = 0;
  logic [7:0] err_flags_i = 8'h00;
  logic sdo_o, sdo_oe_o;
  logic [NR*8-1:0] regs_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  serial_reg_slave #(.NUM_REGS(NR), .CTRL_IDX(15)) u0 (.*);

  // behavioural reference
  bit rxq[$];
  bit txq[$];
  logic [7:0] mregs [NR];
  logic m_sck_p, m_sen_p;
  logic [13:0] m_f;
  logic [7:0] m_val;
  logic [4:0] m_idx;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxq.delete(); txq.delete();
      for (int i = 0; i < NR; i++) mregs[i] = 8'h00;
      m_sck_p = 0; m_sen_p = 0;
    end else begin
      if (sen_i && !m_sen_p) begin
        if (rxq.size() >= 14) begin
          m_f = '0;
          for (int k = 0; k < 14; k++) m_f = {m_f[12:0], 1'(rxq[rxq.size()-14+k])};
          m_idx = {m_f[13], m_f[11:8]};
          if (!m_f[12]) mregs[m_idx] = m_f[7:0];
          else begin
            m_val = (mregs[15][1:0] == 2'b00) ? mregs[m_idx] : err_flags_i;
            txq.delete();
            for (int k = 7; k >= 0; k--) txq.push_back(m_val[k]);
          end
        end
        rxq.delete();
      end else begin
        if (!sck_i && m_sck_p && txq.size() > 0) void'(txq.pop_front());
        if (sck_i && !m_sck_p) rxq.push_back(sdi_i);
      end
      m_sck_p = sck_i; m_sen_p = sen_i;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  logic [NR*8-1:0] exp_regs;
  logic exp_oe;
  always @(posedge clk_i) begin
    #5;
    if (rst_ni && !done) begin
      for (int i = 0; i < NR; i++) exp_regs[i*8 +: 8] = mregs[i];
      exp_oe = (txq.size() > 0) && !oeb_i;
      chk(regs_o == exp_regs, "R2 register bank", 32'(regs_o != exp_regs), 0);
      chk(sdo_oe_o == exp_oe, "R7 output enable", 32'(sdo_oe_o), 32'(exp_oe));
      if (exp_oe) chk(sdo_o == txq[0], "R5 sdo bit", 32'(sdo_o), 32'(txq[0]));
      else        chk(sdo_o == 1'b0, "R7 idle sdo", 32'(sdo_o), 0);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic sck_bit(input bit b, output bit cap);
    sdi_i = b; wait_n(2);
    cap = sdo_o; sck_i = 1; wait_n(2);
    sck_i = 0;
  endtask

  task automatic shift(input logic [15:0] bits, input int n, output logic [7:0] cap);
    bit c;
    cap = '0;
    for (int k = n - 1; k >= 0; k--) begin
      sck_bit(bits[k], c);
      if (n - 1 - k < 8) cap = {cap[6:0], c};
    end
    wait_n(2);
  endtask

  task automatic commit();
    sen_i = 1; wait_n(2); sen_i = 0; wait_n(2);
  endtask

  function automatic logic [5:0] adr(input logic [4:0] idx, input bit rd);
    return {idx[4], rd, idx[3:0]};
  endfunction

  task automatic wr(input logic [4:0] idx, input logic [7:0] d);
    logic [7:0] cap;
    shift({2'b00, adr(idx, 0), d}, 14, cap);
    commit();
  endtask

  task automatic rd(input logic [4:0] idx, input logic [7:0] dummy, output logic [7:0] val);
    logic [7:0] cap;
    shift({2'b00, adr(idx, 1), dummy}, 14, cap);
    commit();
    shift(16'h0000, 8, val);
    wait_n(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, cap;
    wait_n(3);
    // R9 reset state
    chk(regs_o == '0, "R9 regs after reset", 32'(regs_o[31:0]), 0);
    chk(sdo_oe_o == 0, "R9 oe after reset", 32'(sdo_oe_o), 0);
    rst_ni = 1; wait_n(3);

    // R1 R2 plain writes
    wr(5'd0, 8'hC3); wr(5'd17, 8'h81); wr(5'd31, 8'h7E);
    chk(regs_o[0 +: 8] == 8'hC3, "R2 reg0", regs_o[0 +: 8], 8'hC3);
    chk(regs_o[17*8 +: 8] == 8'h81, "R2 reg17", regs_o[17*8 +: 8], 8'h81);
    chk(regs_o[31*8 +: 8] == 8'h7E, "R1 reg31", regs_o[31*8 +: 8], 8'h7E);

    // R1 extra leading bits are dropped
    shift({2'b11, adr(5'd6, 0), 8'h5A}, 16, cap); commit();
    chk(regs_o[6*8 +: 8] == 8'h5A, "R1 last 14 bits", regs_o[6*8 +: 8], 8'h5A);

    // R3 short frame ignored, shifter cleared
    wr(5'd3, 8'h77);
    shift({6'b0, adr(5'd3, 0), 4'h1}, 10, cap); commit();
    chk(regs_o[3*8 +: 8] == 8'h77, "R3 short frame", regs_o[3*8 +: 8], 8'h77);
    wr(5'd3, 8'h11);
    chk(regs_o[3*8 +: 8] == 8'h11, "R3 cleared shifter", regs_o[3*8 +: 8], 8'h11);

    // R4 R5 read back, dummy word writes nothing
    rd(5'd17, 8'hFF, v);
    chk(v == 8'h81, "R4 read reg17", v, 8'h81);
    chk(regs_o[17*8 +: 8] == 8'h81, "R4 reg17 kept", regs_o[17*8 +: 8], 8'h81);
    rd(5'd6, 8'h00, v);
    chk(v == 8'h5A, "R5 read reg6", v, 8'h5A);

    // R6 error flags replace data
    err_flags_i = 8'hA5;
    wr(5'd15, 8'h02);
    rd(5'd0, 8'h00, v);
    chk(v == 8'hA5, "R6 error flags", v, 8'hA5);
    wr(5'd15, 8'h00);
    rd(5'd0, 8'h00, v);
    chk(v == 8'hC3, "R6 mode 00 data", v, 8'hC3);

    // R7 output held off by oeb
    oeb_i = 1;
    rd(5'd0, 8'h00, v);
    chk(v == 8'h00, "R7 oeb high", v, 8'h00);
    oeb_i = 0;

    // R8 write shifted in while read shifts out
    shift({2'b00, adr(5'd31, 1), 8'h00}, 14, cap); commit();
    shift({2'b00, adr(5'd4, 0), 8'h3C}, 14, cap); commit();
    chk(cap == 8'h7E, "R8 overlapped read", cap, 8'h7E);
    chk(regs_o[4*8 +: 8] == 8'h3C, "R8 overlapped write", regs_o[4*8 +: 8], 8'h3C);

    // R9 reset mid-run
    rst_ni = 0; wait_n(2);
    chk(regs_o == '0, "R9 regs cleared", 32'(regs_o[31:0]), 0);
    chk(sdo_oe_o == 0, "R9 oe low", 32'(sdo_oe_o), 0);
    rst_ni = 1; wait_n(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule